// File: doc/BRIEF.md
# Serially Configured Watchdog Reset Supervisor

This block is a supervisor that drives an active-low system reset. The reset is held low for a fixed interval after the block's own reset is released. It is also pulsed low whenever a free-running watchdog count reaches the selected timeout. Software keeps the system alive by pulling chip select low, which restarts the count.

The timeout is chosen by a 2-bit setting held inside the block. The setting is reached through a mode-0 serial slave: data is sampled on rising clock edges, the output changes on falling edges, and every byte travels MSB first. Changing the setting takes two steps. First an unlock instruction sets a change latch. Then a write instruction carries the new value. Each accepted write starts an emulated nonvolatile write cycle of fixed length. While that cycle runs, a read returns an all-ones busy marker. When the cycle finishes, the change latch clears itself.

The serial inputs are assumed to be synchronous to the system clock already. Edges are detected by comparing each input with its value one clock earlier.

Top module: `wdt_spi_supervisor`

## Requirements
- R1: For RST_CYCLES clock cycles after rst_n is released, rst_out_n is low and spi_miso_oe is low. The setting resets to 00 and the change latch resets to clear.
- R2: Opcode 0x06 sets the change latch and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly 8 serial clocks.
- R3: Opcode 0x01 followed by a data byte loads data bits 4 and 3 into the setting (bit 4 is the high bit). The load happens only if all of these hold: chip select rises after exactly 16 clocks, the latch is already set, no write cycle is busy, and data bits 7:5 and 2:0 are zero. Otherwise the setting and the latch keep their values.
- R4: Opcode 0x05 returns one byte, MSB first, with the setting at bits 4:3 and zeros in every other bit. spi_miso_oe is high throughout that data byte.
- R5: An accepted write keeps the block busy for NVW_CYCLES cycles. A read issued while busy returns 0xFF. When the busy cycle ends, the change latch clears.
- R6: The reset pulse fires after this many cycles without a chip-select fall: LONG_CYCLES for setting 00, MED_CYCLES for 01, SHORT_CYCLES for 10. Setting 11 stops the watchdog.
- R7: A watchdog-triggered reset pulse lasts RST_CYCLES cycles. The watchdog count restarts from zero when the pulse ends.
- R8: Every falling edge of chip select restarts the watchdog count.
- R9: Opcodes other than 0x01, 0x04, 0x05 and 0x06 leave the setting and the change latch unchanged.
- R10: spi_miso_oe is low while chip select is high. A transaction whose chip select was already low when reset was released is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| rst_out_n | output | 1 | Active-low supervisor reset |

## Verification
A wrong setting register becomes visible at the ports within one read transaction. It also appears as a high interval of the wrong length between two reset pulses. A stuck change latch is exposed by the next write: the write is either accepted when it should not be, or dropped when it should land. The following read then shows the result. A busy counter of the wrong length shows up as a read that returns the busy marker too early or too late. It also shows up as the latch clearing at the wrong time. The watchdog and pulse counters are checked by measuring, to the exact cycle, how long rst_out_n stays high and how long it stays low.

// File: rtl/wdt_spi_supervisor.sv
module wdt_spi_supervisor #(
  parameter int unsigned LONG_CYCLES  = 14000,
  parameter int unsigned MED_CYCLES   = 6000,
  parameter int unsigned SHORT_CYCLES = 2000,
  parameter int unsigned RST_CYCLES   = 100,
  parameter int unsigned NVW_CYCLES   = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic rst_out_n
);

  localparam int unsigned PMAX = (LONG_CYCLES > MED_CYCLES) ?
                                 ((LONG_CYCLES > SHORT_CYCLES) ? LONG_CYCLES : SHORT_CYCLES) :
                                 ((MED_CYCLES > SHORT_CYCLES) ? MED_CYCLES : SHORT_CYCLES);
  localparam int unsigned CW = $clog2(PMAX + 1);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);
  localparam int unsigned BW = $clog2(NVW_CYCLES + 1);

  localparam logic [7:0] OP_UNLOCK = 8'h06;
  localparam logic [7:0] OP_LOCK   = 8'h04;
  localparam logic [7:0] OP_WRITE  = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h05;

  logic          sck_q, cs_q, armed, rd_act, oe_q, latch;
  logic [4:0]    bit_cnt;
  logic [7:0]    sh, op, out_sr;
  logic [1:0]    wd;
  logic [BW-1:0] busy_cnt;
  logic [CW-1:0] wdt_cnt, period;
  logic [RW-1:0] pulse_cnt;

  wire sck_rise = spi_sck & ~sck_q;
  wire sck_fall = ~spi_sck & sck_q;
  wire cs_fall  = ~spi_cs_n & cs_q;
  wire cs_rise  = spi_cs_n & ~cs_q;
  wire busy     = (busy_cnt != '0);
  wire [7:0] sh_nx = {sh[6:0], spi_mosi};
  wire data_ok  = (sh[7:5] == 3'b000) && (sh[2:0] == 3'b000);

  assign spi_miso    = oe_q & out_sr[7];
  assign spi_miso_oe = oe_q;
  assign rst_out_n   = (pulse_cnt == '0);

  // serial shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      armed   <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
      op      <= '0;
      out_sr  <= '0;
      rd_act  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      sck_q <= spi_sck;
      cs_q  <= spi_cs_n;
      oe_q  <= ~spi_cs_n & rd_act & (bit_cnt >= 5'd8) & (bit_cnt < 5'd16);
      if (cs_fall) begin
        armed   <= 1'b1;
        bit_cnt <= '0;
        rd_act  <= 1'b0;
      end else if (cs_rise) begin
        rd_act <= 1'b0;
      end else if (armed && !spi_cs_n && sck_rise) begin
        sh <= sh_nx;
        if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
        if (bit_cnt == 5'd7) begin
          op <= sh_nx;
          if (sh_nx == OP_READ) begin
            rd_act <= 1'b1;
            out_sr <= busy ? 8'hFF : {3'b000, wd, 3'b000};
          end
        end
      end else if (rd_act && sck_fall && bit_cnt >= 5'd9) begin
        out_sr <= {out_sr[6:0], out_sr[0]};
      end
    end
  end

  // setting, change latch, emulated nonvolatile cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch    <= 1'b0;
      wd       <= 2'b00;
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
      if (busy_cnt == BW'(1)) latch <= 1'b0;
    end else if (cs_rise && armed) begin
      if (bit_cnt == 5'd8 && op == OP_UNLOCK) latch <= 1'b1;
      if (bit_cnt == 5'd8 && op == OP_LOCK)   latch <= 1'b0;
      if (bit_cnt == 5'd16 && op == OP_WRITE && latch && data_ok) begin
        wd       <= sh[4:3];
        busy_cnt <= BW'(NVW_CYCLES);
      end
    end
  end

  always_comb begin
    case (wd)
      2'b00:   period = CW'(LONG_CYCLES);
      2'b01:   period = CW'(MED_CYCLES);
      default: period = CW'(SHORT_CYCLES);
    endcase
  end

  // watchdog and reset pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= RW'(RST_CYCLES);
      wdt_cnt   <= '0;
    end else if (pulse_cnt != '0) begin
      pulse_cnt <= pulse_cnt - 1'b1;
      wdt_cnt   <= '0;
    end else if (cs_fall) begin
      wdt_cnt <= '0;
    end else if (wd != 2'b11) begin
      if (wdt_cnt == period - 1'b1) begin
        pulse_cnt <= RW'(RST_CYCLES);
        wdt_cnt   <= '0;
      end else begin
        wdt_cnt <= wdt_cnt + 1'b1;
      end
    end
  end

  // R10
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> !$past(spi_cs_n));

  // R5
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !latch);

  // R3
  wd_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd) |-> ($rose(busy) && $past(latch)));

  // R2
  latch_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch) |-> (($past(spi_cs_n) && !$past(cs_q)) || $fell(busy)));

  // R7
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (wdt_cnt == '0));

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd == 2'b11) |=> ($stable(wdt_cnt) || wdt_cnt == '0));

endmodule

// File: tb/tb_wdt_spi_supervisor.sv
module tb_wdt_spi_supervisor;
  localparam int LONG = 700, MED = 300, SHORT = 100, RSTC = 20, NVW = 200;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, oe, rst_out_n;
  int checks = 0, failures = 0;

  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  wdt_spi_supervisor #(.LONG_CYCLES(LONG), .MED_CYCLES(MED), .SHORT_CYCLES(SHORT),
                       .RST_CYCLES(RSTC), .NVW_CYCLES(NVW)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .rst_out_n(rst_out_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic spi(input logic [23:0] bits, input int n, output logic [7:0] rx, output bit oe_ok);
    rx = 8'h00; oe_ok = 1'b1;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = bits[23-i];
      repeat (4) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rx = {rx[6:0], miso};
        if (!oe) oe_ok = 1'b0;
      end
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd8(input logic [7:0] opc);
    logic [7:0] rx; bit ok;
    spi({opc, 16'h0}, 8, rx, ok);
  endtask

  task automatic wr(input logic [7:0] d, input int n);
    logic [7:0] rx; bit ok;
    spi({8'h01, d, 8'h00}, n, rx, ok);
  endtask

  task automatic rd_expect(input logic [7:0] e, input string tag);
    logic [7:0] rx; bit ok;
    exp_q.push_back(e); tag_q.push_back(tag);
    spi({8'h05, 16'h0}, 16, rx, ok);
    got_q.push_back(rx);
    chk(ok, "R4 miso_oe high during data byte", int'(ok), 1);
    chk(!oe, "R10 miso_oe low with cs high", int'(oe), 0);
  endtask

  task automatic measure(output int lo, output int hi);
    while (rst_out_n) @(negedge clk);
    lo = 0; hi = 0;
    while (!rst_out_n) begin lo++; @(negedge clk); end
    while (rst_out_n)  begin hi++; @(negedge clk); end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      wait (got_q.size() != 0);
      begin
        logic [7:0] g, e; string t;
        g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    summary();
  end

  initial begin
    int lo, hi;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(!oe, "R1 oe low after reset", int'(oe), 0);
    lo = 0;
    while (!rst_out_n) begin lo++; @(negedge clk); end
    chk(lo == RSTC, "R1 power-up pulse length", lo, RSTC);
    hi = 0;
    while (rst_out_n) begin hi++; @(negedge clk); end
    chk(hi == LONG, "R6 default setting 00 long period", hi, LONG);
    lo = 0;
    while (!rst_out_n) begin lo++; @(negedge clk); end
    chk(lo == RSTC, "R7 watchdog pulse length", lo, RSTC);

    rd_expect(8'h00, "R4 read after reset");
    wr(8'h10, 16);
    rd_expect(8'h00, "R3 write without latch ignored");

    cmd8(8'h06);
    wr(8'h08, 16);
    rd_expect(8'hFF, "R5 busy marker during write cycle");
    repeat (NVW + 10) @(negedge clk);
    rd_expect(8'h08, "R4 setting 01 read back");
    wr(8'h10, 16);
    repeat (NVW + 10) @(negedge clk);
    rd_expect(8'h08, "R5 latch auto-cleared after write");

    measure(lo, hi);
    measure(lo, hi);
    chk(lo == RSTC, "R7 pulse length at setting 01", lo, RSTC);
    chk(hi == MED, "R6 medium period", hi, MED);

    cmd8(8'h06);
    cmd8(8'h04);
    wr(8'h10, 16);
    rd_expect(8'h08, "R2 lock opcode clears latch");

    cmd8(8'h06);
    wr(8'h10, 17);
    rd_expect(8'h08, "R3 seventeen clocks discarded");
    wr(8'h11, 16);
    rd_expect(8'h08, "R3 reserved bits rejected");
    wr(8'h10, 16);
    repeat (NVW + 10) @(negedge clk);
    rd_expect(8'h10, "R3 latch kept after rejects, setting 10 loaded");
    measure(lo, hi);
    measure(lo, hi);
    chk(hi == SHORT, "R6 short period", hi, SHORT);

    cmd8(8'h06);
    cmd8(8'h02);
    cmd8(8'hA5);
    wr(8'h18, 16);
    repeat (NVW + 10) @(negedge clk);
    rd_expect(8'h18, "R9 unknown opcodes left latch set");
    lo = 0;
    repeat (3 * LONG) begin @(negedge clk); if (!rst_out_n) lo++; end
    chk(lo == 0, "R6 setting 11 disables watchdog", lo, 0);

    cmd8(8'h06);
    wr(8'h10, 16);
    lo = 0;
    for (int k = 0; k < 12; k++) begin
      cs_n = 1'b0; @(negedge clk); cs_n = 1'b1;
      repeat (49) begin @(negedge clk); if (!rst_out_n) lo++; end
    end
    chk(lo == 0, "R8 chip-select falls restart watchdog", lo, 0);
    hi = 0;
    while (rst_out_n && hi < 2 * SHORT) begin hi++; @(negedge clk); end
    chk(!rst_out_n, "R8 pulse returns once toggling stops", int'(rst_out_n), 0);

    cs_n = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      mosi = (8'h06 >> (7 - i)) & 1'b1;
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(8'h10, 16);
    repeat (NVW + 10) @(negedge clk);
    rd_expect(8'h00, "R10 unarmed transaction ignored");

    wait (got_q.size() == 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule